// File: doc/BRIEF.md
# Configurable pin interrupt controller

This block watches eight input pins and drives one interrupt line per pin. Every channel is either edge sensitive or level sensitive, chosen by its bit in a mode register. Two per-channel enable registers shape the trigger, and software changes them only through set and clear write addresses.

In edge mode, enable A arms rising edges and enable B arms falling edges. An armed edge sets a sticky status bit, and software clears that bit with a write-one-to-clear. In level mode, enable A turns the channel on and enable B picks the active polarity (1 = high, 0 = low). The interrupt then follows the synchronised pin with no latching.

Because enable B means polarity in level mode, a level channel whose enable B is still 0 fires at once if its pin rests low. Software that needs a quiet start writes enable B before enable A. Each pin passes through a two-flop synchroniser. Edges are found by comparing the synchronised value with its value one cycle earlier.

The register interface is plain and synchronous. It has a write strobe, a 3-bit address and write data. Read data is combinational from the address. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, the mode, enable A, enable B and status registers read 0, and every `irq_o` bit is 0.
- R2: Address 0 is the mode register (bit n = channel n; 0 = edge, 1 = level). A write stores `wr_data`, and a read returns the stored value.
- R3: Writing 1s to address 1 sets bits of enable A, and writing 1s to address 2 clears them. Addresses 3 and 4 do the same for enable B. Zero bits leave a channel unchanged. Reads of 1 or 2 return enable A, and reads of 3 or 4 return enable B.
- R4: In edge mode with enable A set, a rising synchronised edge sets status bit n. `irq_o[n]` goes high three clock edges after the pin changes, and it stays high after the pin falls back.
- R5: In edge mode with enable B set, a falling edge sets the status bit in the same way. An edge whose enable bit is 0 sets nothing.
- R6: Address 5 reads the status register. Writing 1 to bit n there clears it, unless an edge sets it in the same cycle, in which case the set wins.
- R7: In level mode, `irq_o[n]` is 1 exactly when enable A is 1 and the synchronised pin equals enable B. This holds in the cycle right after enabling, including a low pin with polarity 0.
- R8: While both enable bits of a channel are 0, its `irq_o` bit is 0 in either mode.
- R9: Writing the status register has no effect on a level-mode interrupt.
- R10: A mode write that moves a channel from edge to level clears that channel's status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| wr_data | input | 8 | Write data, one bit per channel |
| rd_data | output | 8 | Read data for `reg_addr` |
| pin_i | input | 8 | Asynchronous input pins |
| irq_o | output | 8 | Per-channel interrupt lines |

## Verification
A corrupt enable or mode bit shows on `irq_o` in the same cycle for level channels, because their output is combinational from state. An edge channel shows the fault at its next edge. A status bit that is wrongly set or missed shows on `irq_o` one cycle after the faulty edge. A synchroniser of the wrong depth moves every level and edge response by a whole cycle, so per-cycle comparison catches it. A register fault also shows on `rd_data` as soon as that address is selected.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] SEL_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] SEL_A_SET = 3'd1;
  localparam logic [ADDR_W-1:0] SEL_A_CLR = 3'd2;
  localparam logic [ADDR_W-1:0] SEL_B_SET = 3'd3;
  localparam logic [ADDR_W-1:0] SEL_B_CLR = 3'd4;
  localparam logic [ADDR_W-1:0] SEL_STAT  = 3'd5;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= raw_i;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/pin_cfg_regs.sv
module pin_cfg_regs
  import pin_irq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [N-1:0]      wr_data,
  output logic [N-1:0]      mode_o,
  output logic [N-1:0]      en_a_o,
  output logic [N-1:0]      en_b_o,
  output logic [N-1:0]      stat_clr_o,
  output logic [N-1:0]      to_level_o
);
  logic [N-1:0] mode_q, en_a_q, en_b_q;
  logic wr_mode, wr_aset, wr_aclr, wr_bset, wr_bclr, wr_stat;

  always_comb begin
    wr_mode = wr_en && (reg_addr == SEL_MODE);
    wr_aset = wr_en && (reg_addr == SEL_A_SET);
    wr_aclr = wr_en && (reg_addr == SEL_A_CLR);
    wr_bset = wr_en && (reg_addr == SEL_B_SET);
    wr_bclr = wr_en && (reg_addr == SEL_B_CLR);
    wr_stat = wr_en && (reg_addr == SEL_STAT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      en_a_q <= '0;
      en_b_q <= '0;
    end else begin
      if (wr_mode) mode_q <= wr_data;
      if (wr_aset) en_a_q <= en_a_q | wr_data;
      else if (wr_aclr) en_a_q <= en_a_q & ~wr_data;
      if (wr_bset) en_b_q <= en_b_q | wr_data;
      else if (wr_bclr) en_b_q <= en_b_q & ~wr_data;
    end
  end

  assign mode_o     = mode_q;
  assign en_a_o     = en_a_q;
  assign en_b_o     = en_b_q;
  assign stat_clr_o = wr_stat ? wr_data : '0;
  assign to_level_o = wr_mode ? (wr_data & ~mode_q) : '0;
endmodule

// File: rtl/pin_chan_logic.sv
module pin_chan_logic #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_s,
  input  logic [N-1:0] mode,
  input  logic [N-1:0] en_a,
  input  logic [N-1:0] en_b,
  input  logic [N-1:0] stat_clr,
  input  logic [N-1:0] to_level,
  output logic [N-1:0] status_o,
  output logic [N-1:0] hit_o,
  output logic [N-1:0] irq_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_s;
  end

  for (genvar g = 0; g < N; g++) begin : g_ch
    logic rise, fall, hit, stat_q, lvl_on, edge_on;

    always_comb begin
      rise    = pin_s[g] & ~prev_q[g];
      fall    = ~pin_s[g] & prev_q[g];
      hit     = ~mode[g] & ((rise & en_a[g]) | (fall & en_b[g]));
      lvl_on  = mode[g] & en_a[g] & (pin_s[g] == en_b[g]);
      edge_on = ~mode[g] & stat_q & (en_a[g] | en_b[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           stat_q <= 1'b0;
      else if (to_level[g]) stat_q <= 1'b0;
      else if (hit)         stat_q <= 1'b1;
      else if (stat_clr[g]) stat_q <= 1'b0;
    end

    assign status_o[g] = stat_q;
    assign hit_o[g]    = hit;
    assign irq_o[g]    = lvl_on | edge_on;
  end
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int N           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [N-1:0]      wr_data,
  output logic [N-1:0]      rd_data,
  input  logic [N-1:0]      pin_i,
  output logic [N-1:0]      irq_o
);
  logic [N-1:0] pin_s, mode_q, en_a_q, en_b_q, stat_clr, to_level, stat_q, hit_w;

  pin_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(pin_i), .sync_o(pin_s)
  );

  pin_cfg_regs #(.N(N)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .mode_o(mode_q), .en_a_o(en_a_q), .en_b_o(en_b_q),
    .stat_clr_o(stat_clr), .to_level_o(to_level)
  );

  pin_chan_logic #(.N(N)) u_chan (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .mode(mode_q), .en_a(en_a_q),
    .en_b(en_b_q), .stat_clr(stat_clr), .to_level(to_level),
    .status_o(stat_q), .hit_o(hit_w), .irq_o(irq_o)
  );

  always_comb begin
    unique case (reg_addr)
      SEL_MODE:             rd_data = mode_q;
      SEL_A_SET, SEL_A_CLR: rd_data = en_a_q;
      SEL_B_SET, SEL_B_CLR: rd_data = en_b_q;
      SEL_STAT:             rd_data = stat_q;
      default:              rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk
  import pin_irq_pkg::*;
#(
  parameter int N = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [N-1:0]      wr_data,
  input logic [N-1:0]      irq_o,
  input logic [N-1:0]      pin_s,
  input logic [N-1:0]      mode,
  input logic [N-1:0]      en_a,
  input logic [N-1:0]      en_b,
  input logic [N-1:0]      stat,
  input logic [N-1:0]      hit
);
  always @(posedge clk) begin
    if (!rst_n) AST_RESET_QUIET: assert (irq_o == '0 && mode == '0 && stat == '0); // R1
  end

  AST_MODE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == SEL_MODE) |=> (mode == $past(wr_data))); // R2
  AST_ENA_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == SEL_A_SET) |=> ((en_a & $past(wr_data)) == $past(wr_data))); // R3
  AST_ENB_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == SEL_B_CLR) |=> ((en_b & $past(wr_data)) == '0)); // R3
  AST_EDGE_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~mode & ~stat) == '0)); // R4
  AST_STAT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == SEL_STAT) |=> ((stat & $past(wr_data) & ~$past(hit)) == '0)); // R6
  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & mode) == (mode & en_a & ~(pin_s ^ en_b)))); // R7
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~(en_a | en_b)) == '0)); // R8
  AST_TO_LEVEL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == SEL_MODE) |=> ((stat & $past(wr_data & ~mode)) == '0)); // R10
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data),
  .irq_o(irq_o), .pin_s(pin_s), .mode(mode_q), .en_a(en_a_q), .en_b(en_b_q),
  .stat(stat_q), .hit(hit_w)
);

// File: tb/sim_pin_irq_ctrl.sv
`timescale 1ns/1ps
module sim_pin_irq_ctrl;
  localparam int N = 8;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] reg_addr = '0;
  logic [N-1:0] wr_data = '0, pin_i = '0, rd_data, irq_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pin_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .pin_i(pin_i), .irq_o(irq_o));

  // behavioural reference state
  bit [N-1:0] m_p1, m_p2, m_old, m_mode, m_a, m_b, m_st;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_p1 = 0; m_p2 = 0; m_old = 0; m_mode = 0; m_a = 0; m_b = 0; m_st = 0;
    end else begin
      bit [N-1:0] nst;
      nst = m_st;
      for (int i = 0; i < N; i++) begin
        bit up, dn;
        up = m_p2[i] && !m_old[i];
        dn = !m_p2[i] && m_old[i];
        if (wr_en && reg_addr == 5 && wr_data[i]) nst[i] = 0;
        if (!m_mode[i] && ((up && m_a[i]) || (dn && m_b[i]))) nst[i] = 1;
        if (wr_en && reg_addr == 0 && wr_data[i] && !m_mode[i]) nst[i] = 0;
      end
      m_st = nst;
      if (wr_en) case (reg_addr)
        0: m_mode = wr_data;
        1: m_a = m_a | wr_data;
        2: m_a = m_a & ~wr_data;
        3: m_b = m_b | wr_data;
        4: m_b = m_b & ~wr_data;
        default: ;
      endcase
      m_old = m_p2; m_p2 = m_p1; m_p1 = pin_i;
    end
  end

  function automatic bit [N-1:0] exp_irq();
    bit [N-1:0] r = 0;
    for (int i = 0; i < N; i++) begin
      if (m_mode[i]) r[i] = m_a[i] && (m_p2[i] == m_b[i]);
      else           r[i] = m_st[i] && (m_a[i] || m_b[i]);
    end
    return r;
  endfunction

  function automatic bit [N-1:0] exp_rd(input int a);
    case (a)
      0: return m_mode;
      1, 2: return m_a;
      3, 4: return m_b;
      5: return m_st;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check((m_mode != 0) ? "R7 irq vs model" : "R4 irq vs model", irq_o, exp_irq());
      check("R3 rd_data vs model", rd_data, exp_rd(reg_addr));
    end
  end

  task automatic wr(input int a, input logic [N-1:0] d);
    @(negedge clk); wr_en = 1; reg_addr = 3'(a); wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = 0;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [N-1:0] e);
    @(negedge clk); reg_addr = 3'(a); #1; check(req, rd_data, e);
  endtask

  task automatic pins_then(input logic [N-1:0] p, input int edges);
    @(negedge clk); pin_i = p;
    repeat (edges) @(posedge clk);
    @(negedge clk); #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1_500_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1; check("R1 irq after reset", irq_o, 8'h00);
    rst_n = 1;
    for (int a = 0; a < 6; a++) rd_chk("R1 register reset value", a, 8'h00);

    wr(0, 8'hA5); rd_chk("R2 mode readback", 0, 8'hA5);
    wr(0, 8'h00); rd_chk("R2 mode rewrite", 0, 8'h00);

    wr(1, 8'h0F); wr(1, 8'h30); rd_chk("R3 enable A set", 1, 8'h3F);
    wr(2, 8'h05); rd_chk("R3 enable A clear", 2, 8'h3A);
    wr(3, 8'hC0); wr(4, 8'h40); rd_chk("R3 enable B set/clear", 3, 8'h80);
    wr(2, 8'hFF); wr(4, 8'hFF); rd_chk("R3 all cleared", 1, 8'h00);

    // level channel 0, pin low, polarity 0: fires on enable
    wr(0, 8'h01); #1; check("R8 level masked", irq_o, 8'h00);
    wr(1, 8'h01); #1; check("R7 immediate low-level fire", irq_o, 8'h01);
    pins_then(8'h01, 1); check("R7 sync delay", irq_o, 8'h01);
    pins_then(8'h01, 1); check("R7 pin high releases", irq_o, 8'h00);
    wr(3, 8'h01); #1; check("R7 active-high matches", irq_o, 8'h01);
    wr(5, 8'hFF); #1; check("R9 status write ignored by level", irq_o, 8'h01);
    wr(2, 8'h01); #1; check("R8 enable A off masks level", irq_o, 8'h00);
    wr(4, 8'h01); wr(0, 8'h00);

    // edge channel 1 rising
    pin_i = 8'h00; repeat (4) @(negedge clk);
    wr(1, 8'h02);
    pins_then(8'h02, 2); check("R4 no irq before 3 edges", irq_o, 8'h00);
    @(posedge clk); @(negedge clk); #1; check("R4 rising edge irq", irq_o, 8'h02);
    pins_then(8'h00, 4); check("R4 sticky after fall", irq_o, 8'h02);
    rd_chk("R6 status read", 5, 8'h02);
    wr(5, 8'h02); #1; check("R6 w1c clears", irq_o, 8'h00);

    // edge channel 2 falling only
    wr(2, 8'h02); wr(3, 8'h04);
    pins_then(8'h04, 4); check("R5 rising ignored", irq_o, 8'h00);
    pins_then(8'h00, 3); check("R5 falling edge irq", irq_o, 8'h04);
    wr(4, 8'h04); #1; check("R8 masked pending edge", irq_o, 8'h00);
    wr(3, 8'h04); #1; check("R5 pending returns", irq_o, 8'h04);
    wr(0, 8'h04); rd_chk("R10 edge-to-level clears status", 5, 8'h00);
    wr(0, 8'h00); #1; check("R10 no stale edge", irq_o, 8'h00);
    wr(4, 8'hFF);

    // random traffic, compared every cycle
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      wr_en = ($urandom % 3) == 0;
      reg_addr = 3'($urandom % 8);
      wr_data = 8'($urandom);
      if (($urandom % 4) == 0) pin_i = pin_i ^ 8'($urandom);
    end
    @(negedge clk); wr_en = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule